// File: doc/BRIEF.md
# Dual-Address I2C Target Interface

This block is a byte-level I2C target (slave) that runs from a fast system clock. It oversamples the SCL and SDA lines and detects START and STOP conditions. It shifts address and data bytes in and out, one per nine bus clocks. The incoming address is compared with two programmable own addresses and with the general call address. The first own address can be either 7-bit or 10-bit wide. On a match the block acknowledges the address and then exchanges data bytes with a local host. The host sees a one-byte receive register with a valid flag and a one-byte transmit register with an empty flag. Single-cycle event pulses report address matches, completed bytes, STOP and errors.

When clock stretching is on, the target holds SCL low after each acknowledge until the host has emptied the receive register or filled the transmit register. When stretching is off, the bus never waits. A byte that arrives while the previous one is unread is dropped and flagged as overrun. A transmit slot with no fresh byte resends the previous one and is flagged as underrun.

The controller is built around nine states:

- IDLE waits for START.
- ADDR shifts in an address byte. It leaves for AACK on a match and for SKIP on a miss.
- AACK drives the acknowledge bit. It goes back to ADDR after a 10-bit header, and otherwise to HOLD.
- HOLD decides the direction and stretches SCL when the host is not ready. It leaves for RXD or TXD.
- RXD shifts in a data byte and then moves to RACK.
- RACK acknowledges the received byte and returns to HOLD.
- TXD drives a byte out and then moves to TACK.
- TACK samples the controller's acknowledge. It returns to HOLD on ACK and goes to SKIP on NACK.
- SKIP stays off the bus.

From any state, START leads to ADDR and STOP leads to IDLE.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: After reset the block releases both lines (scl_oe=0, sda_oe=0). It also shows rx_valid=0, tx_empty=1 and match_id=0.
- R2: In 7-bit mode, an address byte whose upper seven bits equal cfg_own1[6:0] is acknowledged (SDA low in the ninth clock). The block pulses ev_addr and shows match_id=1.
- R3: When cfg_own2_en=1, an address byte whose upper seven bits equal cfg_own2 is acknowledged with match_id=2. When cfg_own2_en=0, the same byte is not acknowledged.
- R4: When cfg_gc_en=1, the address byte 0x00 is acknowledged with match_id=3, and the block acts as a receiver. When cfg_gc_en=0, or for the byte 0x01, there is no acknowledge.
- R5: A non-matching address is not acknowledged. All later bytes are ignored until the next START or STOP: no ACK, no rx_valid and no SCL hold.
- R6: Bit 0 of a matched address selects the direction, with 1 meaning the target transmits (is_tx=1). A transmitted byte is the last one written through tx_data/tx_write, sent MSB first.
- R7: With cfg_addr10=1, own address 1 is matched by a header byte 11110,A9,A8,0 followed by a second byte equal to A7..A0. ev_addr pulses only after the second byte. A later repeated START with header 11110,A9,A8,1 makes the block a transmitter. That read header is refused after a STOP, and 7-bit matching of own address 1 is off in this mode.
- R8: Each received data byte is acknowledged and appears on rx_data with rx_valid=1, and ev_byte pulses. An rx_read pulse clears rx_valid.
- R9: A STOP while addressed pulses ev_stop, returns the block to IDLE and clears match_id to 0.
- R10: A START or STOP that arrives after two or more bits of a byte have been clocked pulses err_bus. These conditions at byte boundaries raise no error.
- R11: With cfg_stretch_en=1, SCL is held low after the acknowledge until the host issues rx_read (receive) or tx_write (transmit). The transfer then continues with the correct data.
- R12: With cfg_stretch_en=0, a byte that completes while rx_valid=1 pulses err_ovr and is discarded, and rx_data keeps the earlier byte.
- R13: With cfg_stretch_en=0, a transmit slot reached with tx_empty=1 pulses err_udr and resends the previously sent byte.
- R14: After the controller answers a transmitted byte with NACK, the target releases SDA and sends nothing more until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_own1 | input | 10 | Own address 1 (low 7 bits used in 7-bit mode) |
| cfg_addr10 | input | 1 | Own address 1 is 10-bit |
| cfg_own2 | input | 7 | Own address 2 (7-bit) |
| cfg_own2_en | input | 1 | Enable own address 2 |
| cfg_gc_en | input | 1 | Enable general call |
| cfg_stretch_en | input | 1 | Enable clock stretching |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Receive register holds an unread byte |
| rx_read | input | 1 | Host read strobe, clears rx_valid |
| tx_data | input | 8 | Byte to transmit |
| tx_write | input | 1 | Host write strobe for tx_data |
| tx_empty | output | 1 | Transmit register needs a new byte |
| match_id | output | 2 | 0 none, 1 own 1, 2 own 2, 3 general call |
| is_tx | output | 1 | Target is transmitter |
| ev_addr | output | 1 | Pulse: address matched |
| ev_byte | output | 1 | Pulse: data byte completed |
| ev_stop | output | 1 | Pulse: STOP while addressed |
| err_bus | output | 1 | Pulse: misplaced START or STOP |
| err_ovr | output | 1 | Pulse: receive overrun |
| err_udr | output | 1 | Pulse: transmit underrun |

## Verification
The assertions take four things for granted about the inputs:

- SCL and SDA edges are spaced well beyond the synchronizer depth plus two clocks.
- SDA moves only while SCL is low, except for deliberate START and STOP conditions.
- The configuration inputs stay constant for the whole time the target is addressed.
- rx_read and tx_write are single-cycle strobes.

The stimulus drives the bus with a quarter bit period of eight clocks. It changes configuration only between transfers, while the bus is free. Host strobes come from one task that raises them for exactly one clock, so the stretch-hold and overrun properties see only legal input sequences.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RXD, ST_RACK,
        ST_TXD, ST_TACK, ST_HOLD, ST_SKIP
    } slv_state_e;

    typedef enum logic [1:0] {
        MID_NONE = 2'd0,
        MID_OWN1 = 2'd1,
        MID_OWN2 = 2'd2,
        MID_GC   = 2'd3
    } match_id_e;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_p, sda_p, scl_s;

    // synchronizer chain, one flop per stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync[0] <= scl_i;
            sda_sync[0] <= sda_i;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                scl_sync[k] <= scl_sync[k-1];
                sda_sync[k] <= sda_sync[k-1];
            end
            scl_p <= scl_sync[LAST];
            sda_p <= sda_sync[LAST];
        end
    end

    always_comb begin
        scl_s     = scl_sync[LAST];
        sda_s     = sda_sync[LAST];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_slave_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              hdr_pend,
    input  logic              ten_done,
    input  logic [9:0]        cfg_own1,
    input  logic              cfg_addr10,
    input  logic [6:0]        cfg_own2,
    input  logic              cfg_own2_en,
    input  logic              cfg_gc_en,
    output logic              hit,
    output logic              hdr_only,
    output match_id_e         hit_id,
    output logic              hit_rw
);
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    logic ten_hdr;

    always_comb begin
        hit      = 1'b0;
        hdr_only = 1'b0;
        hit_id   = MID_NONE;
        hit_rw   = addr_byte[0];
        ten_hdr  = cfg_addr10 && (addr_byte[7:3] == TEN_PREFIX)
                   && (addr_byte[2:1] == cfg_own1[9:8]);
        if (hdr_pend) begin
            // second byte of a 10-bit write address
            hit    = (addr_byte == cfg_own1[7:0]);
            hit_id = hit ? MID_OWN1 : MID_NONE;
            hit_rw = 1'b0;
        end else if (ten_hdr && !addr_byte[0]) begin
            hit      = 1'b1;
            hdr_only = 1'b1;
        end else if (ten_hdr && ten_done) begin
            hit    = 1'b1;
            hit_id = MID_OWN1;
        end else if (!cfg_addr10 && (addr_byte[7:1] == cfg_own1[6:0])) begin
            hit    = 1'b1;
            hit_id = MID_OWN1;
        end else if (cfg_own2_en && (addr_byte[7:1] == cfg_own2)) begin
            hit    = 1'b1;
            hit_id = MID_OWN2;
        end else if (cfg_gc_en && (addr_byte == 8'h00)) begin
            hit    = 1'b1;
            hit_id = MID_GC;
        end
    end

endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
    import i2c_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic [9:0]  cfg_own1,
    input  logic        cfg_addr10,
    input  logic [6:0]  cfg_own2,
    input  logic        cfg_own2_en,
    input  logic        cfg_gc_en,
    input  logic        cfg_stretch_en,
    output logic [7:0]  rx_data,
    output logic        rx_valid,
    input  logic        rx_read,
    input  logic [7:0]  tx_data,
    input  logic        tx_write,
    output logic        tx_empty,
    output logic [1:0]  match_id,
    output logic        is_tx,
    output logic        ev_addr,
    output logic        ev_byte,
    output logic        ev_stop,
    output logic        err_bus,
    output logic        err_ovr,
    output logic        err_udr
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    slv_state_e        st, st_n;
    match_id_e         mid, m_id;
    logic [BYTE_W-1:0] shreg, txsh, rx_buf, tx_buf;
    logic [CNT_W-1:0]  cnt;
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ack_drv, hdr_pend, ten_done, nack;
    logic m_hit, m_hdr, m_rw, hold_go, mid_byte;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_addr_match u_match (
        .addr_byte(shreg), .hdr_pend(hdr_pend), .ten_done(ten_done),
        .cfg_own1(cfg_own1), .cfg_addr10(cfg_addr10), .cfg_own2(cfg_own2),
        .cfg_own2_en(cfg_own2_en), .cfg_gc_en(cfg_gc_en),
        .hit(m_hit), .hdr_only(m_hdr), .hit_id(m_id), .hit_rw(m_rw)
    );

    // receive states count rises, transmit counts falls
    always_comb begin
        mid_byte = ((st == ST_ADDR || st == ST_RXD) && cnt > CNT_W'(1))
                 || (st == ST_TXD && cnt != '0);
        hold_go  = is_tx ? (!tx_empty || !cfg_stretch_en)
                         : (!rx_valid || !cfg_stretch_en);
    end

    // next-state logic
    always_comb begin
        st_n = st;
        if (stop_det) begin
            st_n = ST_IDLE;
        end else if (start_det) begin
            st_n = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE, ST_SKIP: st_n = st;
                ST_ADDR: if (scl_fall && cnt == CNT_FULL) st_n = m_hit ? ST_AACK : ST_SKIP;
                ST_AACK: if (scl_fall) st_n = hdr_pend ? ST_ADDR : ST_HOLD;
                ST_RXD:  if (scl_fall && cnt == CNT_FULL) st_n = ST_RACK;
                ST_RACK: if (scl_fall) st_n = ST_HOLD;
                ST_HOLD: if (hold_go) st_n = is_tx ? ST_TXD : ST_RXD;
                ST_TXD:  if (scl_fall && cnt == CNT_LAST) st_n = ST_TACK;
                ST_TACK: if (scl_fall) st_n = nack ? ST_SKIP : ST_HOLD;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // datapath and event registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0; txsh <= '1; rx_buf <= '0; tx_buf <= '1;
            cnt <= '0; mid <= MID_NONE; is_tx <= 1'b0;
            ack_drv <= 1'b0; hdr_pend <= 1'b0; ten_done <= 1'b0; nack <= 1'b0;
            rx_valid <= 1'b0; tx_empty <= 1'b1;
            ev_addr <= 1'b0; ev_byte <= 1'b0; ev_stop <= 1'b0;
            err_bus <= 1'b0; err_ovr <= 1'b0; err_udr <= 1'b0;
        end else begin
            ev_addr <= 1'b0; ev_byte <= 1'b0; ev_stop <= 1'b0;
            err_bus <= 1'b0; err_ovr <= 1'b0; err_udr <= 1'b0;
            if (rx_read) rx_valid <= 1'b0;
            if (stop_det) begin
                err_bus  <= mid_byte;
                ev_stop  <= (mid != MID_NONE);
                mid      <= MID_NONE;
                is_tx    <= 1'b0;
                ten_done <= 1'b0;
                hdr_pend <= 1'b0;
                ack_drv  <= 1'b0;
                cnt      <= '0;
            end else if (start_det) begin
                err_bus  <= mid_byte;
                hdr_pend <= 1'b0;
                ack_drv  <= 1'b0;
                cnt      <= '0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_RXD: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_FULL) begin
                            cnt     <= '0;
                            ack_drv <= (st == ST_RXD) || m_hit;
                            if (st == ST_RXD) begin
                                ev_byte <= 1'b1;
                                if (rx_valid) begin
                                    err_ovr <= 1'b1;
                                end else begin
                                    rx_buf   <= shreg;
                                    rx_valid <= 1'b1;
                                end
                            end else begin
                                hdr_pend <= m_hit && m_hdr;
                                if (!m_hdr) begin
                                    mid     <= m_id;
                                    is_tx   <= m_hit && m_rw;
                                    ev_addr <= m_hit;
                                end
                                if (m_hit && hdr_pend) ten_done <= 1'b1;
                            end
                        end
                    end
                    ST_AACK, ST_RACK: if (scl_fall) ack_drv <= 1'b0;
                    ST_HOLD: begin
                        cnt <= '0;
                        if (is_tx && hold_go) begin
                            txsh     <= tx_buf;
                            tx_empty <= 1'b1;
                            err_udr  <= tx_empty;
                        end
                    end
                    ST_TXD: if (scl_fall) begin
                        txsh <= {txsh[BYTE_W-2:0], 1'b1};
                        cnt  <= cnt + 1'b1;
                        if (cnt == CNT_LAST) begin
                            cnt     <= '0;
                            ev_byte <= 1'b1;
                        end
                    end
                    ST_TACK: if (scl_rise) nack <= sda_s;
                    default: ;
                endcase
            end
            if (tx_write) begin
                tx_buf   <= tx_data;
                tx_empty <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe   = (st == ST_TXD) ? ~txsh[BYTE_W-1] : ack_drv;
        scl_oe   = (st == ST_HOLD) && !hold_go;
        rx_data  = rx_buf;
        match_id = mid;
    end

    assert_addr_event_has_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr |-> (match_id != 2'd0)) else $error("address event without id");

    assert_gc_is_receiver_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_id == 2'd3) |-> !is_tx) else $error("general call as transmitter");

    assert_skip_is_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> (!sda_oe && !scl_oe)) else $error("unaddressed target drives bus");

    assert_stretch_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !rx_read && !tx_write && !start_det && !stop_det) |=> scl_oe)
        else $error("stretch released without host action");

    assert_overrun_keeps_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovr |-> $stable(rx_data)) else $error("overrun replaced stored byte");

    assert_underrun_only_unstretched_R13: assert property (@(posedge clk) disable iff (!rst_n)
        err_udr |-> !$past(cfg_stretch_en)) else $error("underrun while stretching");

endmodule

// File: tb/i2c_dual_addr_slave_bench.sv
module i2c_dual_addr_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    typedef struct packed {
        logic [7:0] addr;
        logic       ack;
        logic [1:0] id;
        logic [7:0] data;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{addr: 8'h74, ack: 1'b1, id: 2'd1, data: 8'hA5},
        '{addr: 8'h75, ack: 1'b1, id: 2'd1, data: 8'h3C},
        '{addr: 8'hA2, ack: 1'b1, id: 2'd2, data: 8'h0F},
        '{addr: 8'hA3, ack: 1'b1, id: 2'd2, data: 8'hE1},
        '{addr: 8'h00, ack: 1'b1, id: 2'd3, data: 8'h4E},
        '{addr: 8'h01, ack: 1'b0, id: 2'd0, data: 8'h00},
        '{addr: 8'h20, ack: 1'b0, id: 2'd0, data: 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_line, sda_line, scl_oe, sda_oe;
    logic [9:0] cfg_own1 = 10'h03A;
    logic cfg_addr10 = 1'b0;
    logic [6:0] cfg_own2 = 7'h51;
    logic cfg_own2_en = 1'b1, cfg_gc_en = 1'b1, cfg_stretch_en = 1'b0;
    logic [7:0] rx_data, tx_data = 8'h00;
    logic rx_valid, rx_read = 1'b0, tx_write = 1'b0, tx_empty, is_tx;
    logic [1:0] match_id;
    logic ev_addr, ev_byte, ev_stop, err_bus, err_ovr, err_udr;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_dual_addr_slave u_i2c_dual_addr_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_own1(cfg_own1), .cfg_addr10(cfg_addr10),
        .cfg_own2(cfg_own2), .cfg_own2_en(cfg_own2_en), .cfg_gc_en(cfg_gc_en),
        .cfg_stretch_en(cfg_stretch_en), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_read(rx_read), .tx_data(tx_data), .tx_write(tx_write), .tx_empty(tx_empty),
        .match_id(match_id), .is_tx(is_tx), .ev_addr(ev_addr), .ev_byte(ev_byte),
        .ev_stop(ev_stop), .err_bus(err_bus), .err_ovr(err_ovr), .err_udr(err_udr)
    );

    int n_addr = 0, n_byte = 0, n_stop = 0, n_bus = 0, n_ovr = 0, n_udr = 0;
    always @(negedge clk) begin
        if (ev_addr) n_addr++;
        if (ev_byte) n_byte++;
        if (ev_stop) n_stop++;
        if (err_bus) n_bus++;
        if (err_ovr) n_ovr++;
        if (err_udr) n_udr++;
    end

    int total = 0, bad = 0, stretch_cyc = 0;
    logic [7:0] rd, rd2;
    logic ackb;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        tick(1);
        while (!scl_line) begin
            stretch_cyc++;
            tick(1);
        end
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q); scl_up(); tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q); scl_up(); tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; tick(Q); scl_up(); tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; tick(Q); scl_up(); tick(Q / 2);
        b = sda_line; tick(Q / 2); scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = !b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(!ack);
    endtask

    task automatic host_read();
        rx_read = 1'b1; tick(1); rx_read = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        tx_data = d; tx_write = 1'b1; tick(1); tx_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int a0, s0, b0, o0, u0;
        string req;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(rx_valid == 1'b0 && tx_empty == 1'b1, "R1 register flags", {rx_valid, tx_empty}, 1);
        chk(match_id == 2'd0, "R1 match id", match_id, 0);

        // table of address patterns
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            req = (v.id == 2'd1) ? "R2" : (v.id == 2'd2) ? "R3" : (v.id == 2'd3) ? "R4" : "R5";
            a0 = n_addr; s0 = n_stop;
            if (v.ack && v.addr[0]) host_write(v.data);
            m_start();
            wbyte(v.addr, ackb);
            chk(ackb == v.ack, {req, " address ack"}, ackb, v.ack);
            chk(match_id == v.id, {req, " match id"}, match_id, v.id);
            chk(n_addr - a0 == int'(v.ack), {req, " ev_addr count"}, n_addr - a0, v.ack);
            if (v.ack && v.addr[0]) begin
                chk(is_tx == 1'b1, "R6 direction tx", is_tx, 1);
                rbyte(rd, 1'b0);
                chk(rd == v.data, "R6 transmitted byte", rd, v.data);
            end else if (v.ack) begin
                chk(is_tx == 1'b0, "R6 direction rx", is_tx, 0);
                wbyte(v.data, ackb);
                chk(ackb == 1'b1, "R8 data ack", ackb, 1);
                chk(rx_valid == 1'b1 && rx_data == v.data, "R8 received byte", rx_data, v.data);
                host_read();
                tick(1);
                chk(rx_valid == 1'b0, "R8 read clears valid", rx_valid, 0);
            end
            m_stop();
            chk(n_stop - s0 == int'(v.ack), "R9 stop event", n_stop - s0, v.ack);
            chk(match_id == 2'd0, "R9 match cleared", match_id, 0);
        end

        // R3 own address 2 disabled
        cfg_own2_en = 1'b0;
        m_start(); wbyte(8'hA2, ackb); m_stop();
        chk(ackb == 1'b0, "R3 disabled own2 nack", ackb, 0);
        cfg_own2_en = 1'b1;

        // R4 general call disabled
        cfg_gc_en = 1'b0;
        m_start(); wbyte(8'h00, ackb); m_stop();
        chk(ackb == 1'b0, "R4 disabled gc nack", ackb, 0);
        cfg_gc_en = 1'b1;

        // R5 later bytes ignored after a miss
        m_start(); wbyte(8'h20, ackb); wbyte(8'h74, ackb);
        chk(ackb == 1'b0 && rx_valid == 1'b0, "R5 ignored byte", {ackb, rx_valid}, 0);
        m_stop();

        // R10 misplaced START and STOP
        b0 = n_bus;
        m_start(); wbit(1'b0); wbit(1'b1); wbit(1'b1);
        m_start(); wbit(1'b1); wbit(1'b0); wbit(1'b1);
        m_stop();
        chk(n_bus - b0 == 2, "R10 bus errors", n_bus - b0, 2);

        // R12 overrun
        o0 = n_ovr; s0 = n_byte;
        m_start(); wbyte(8'h74, ackb); wbyte(8'h11, ackb); wbyte(8'h22, ackb);
        chk(n_ovr - o0 == 1, "R12 overrun flagged", n_ovr - o0, 1);
        chk(rx_data == 8'h11 && rx_valid, "R12 first byte kept", rx_data, 8'h11);
        chk(n_byte - s0 == 2, "R8 byte events", n_byte - s0, 2);
        host_read(); m_stop();

        // R11 stretch on receive
        cfg_stretch_en = 1'b1;
        m_start(); wbyte(8'h74, ackb); wbyte(8'h5A, ackb);
        chk(scl_oe == 1'b1, "R11 rx hold", scl_oe, 1);
        chk(rx_data == 8'h5A, "R11 first rx byte", rx_data, 8'h5A);
        stretch_cyc = 0;
        fork
            wbyte(8'h66, ackb);
            begin
                tick(40);
                chk(scl_oe == 1'b1, "R11 rx still held", scl_oe, 1);
                host_read();
            end
        join
        chk(stretch_cyc >= 25, "R11 rx stretch length", stretch_cyc, 25);
        chk(rx_data == 8'h66 && ackb, "R11 second rx byte", rx_data, 8'h66);
        host_read(); m_stop();

        // R11 stretch on transmit
        m_start(); wbyte(8'h75, ackb);
        stretch_cyc = 0;
        fork
            rbyte(rd, 1'b0);
            begin
                tick(50);
                host_write(8'h9C);
            end
        join
        chk(rd == 8'h9C, "R11 tx byte after hold", rd, 8'h9C);
        chk(stretch_cyc >= 30, "R11 tx stretch length", stretch_cyc, 30);
        m_stop();
        cfg_stretch_en = 1'b0;

        // R13 underrun and R14 release after NACK
        u0 = n_udr;
        host_write(8'hB7);
        m_start(); wbyte(8'h75, ackb);
        rbyte(rd, 1'b1); rbyte(rd2, 1'b0);
        chk(rd == 8'hB7 && rd2 == 8'hB7, "R13 resent byte", rd2, 8'hB7);
        chk(n_udr - u0 == 1, "R13 underrun flagged", n_udr - u0, 1);
        tick(30);
        chk(sda_oe == 1'b0, "R14 sda released", sda_oe, 0);
        m_stop();

        // R7 10-bit own address
        cfg_addr10 = 1'b1; cfg_own1 = 10'h2C5;
        a0 = n_addr;
        m_start(); wbyte(8'hF4, ackb);
        chk(ackb && n_addr == a0, "R7 header ack no event", n_addr - a0, 0);
        wbyte(8'hC5, ackb);
        chk(ackb && n_addr - a0 == 1 && match_id == 2'd1, "R7 full match", match_id, 1);
        wbyte(8'h3C, ackb);
        chk(rx_data == 8'h3C, "R7 data after 10-bit", rx_data, 8'h3C);
        host_read();
        host_write(8'h81);
        m_start(); wbyte(8'hF5, ackb);
        chk(ackb && is_tx, "R7 read header", {ackb, is_tx}, 3);
        rbyte(rd, 1'b0);
        chk(rd == 8'h81, "R7 read data", rd, 8'h81);
        m_stop();
        m_start(); wbyte(8'hF5, ackb); m_stop();
        chk(ackb == 1'b0, "R7 read header refused after stop", ackb, 0);
        m_start(); wbyte(8'h8A, ackb); m_stop();
        chk(ackb == 1'b0, "R7 no 7-bit match in 10-bit mode", ackb, 0);

        chk(n_bus - b0 == 2, "R10 no errors at byte boundaries", n_bus - b0, 2);
        finish_run();
    end

endmodule